// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block counts down a programmable timeout in units of an external 1/16-second tick and reports expiry. The timeout comes from one byte-wide control register: its low two bits select a resolution of 1, 4, 16 or 64 ticks, and the next five bits give a multiplier. A control value whose multiplier is zero holds the watchdog idle.

Any write or read of the control register counts as service. It clears the expiry flag and restarts the countdown. A write reloads from the new value and a read reloads from the stored one. When the count runs out, the block raises a sticky expiry flag. The top bit of the control register then picks what follows. With the bit clear, the block emits one interrupt pulse. With the bit set, it emits a one-cycle reset request and a one-cycle strobe that clears the century bit held in a neighbouring register, and it zeroes its own control register. The system reset itself is produced elsewhere.

The register port uses plain single-cycle strobes with no back-pressure. There is no data stream here, so there is no valid/ready handshake: a strobe is taken in the cycle it is high, and read data is the stored control value, available combinationally.

Top module: `wdog_steer`

## Requirements
- R1: The timeout equals (1 << (2 × ctl[1:0])) × ctl[6:2] ticks. A tick that arrives in the same cycle as a register access is not counted. Expiry becomes visible at the ports in the cycle after the clock edge that takes the last tick.
- R2: When ctl[6:2] is zero, the computed timeout is zero, no countdown runs, and no flag, interrupt or reset request appears, however many ticks arrive.
- R3: A write (reg_wr high) stores reg_wdata, clears wd_flag on the next edge, and restarts the countdown from the new value. reg_rdata shows the stored value from the next cycle onward.
- R4: A read (reg_rd high) clears wd_flag on the next edge and restarts the countdown from the stored value. The stored value does not change.
- R5: Expiry sets wd_flag. The flag stays set until the next register access.
- R6: On expiry with ctl[7] = 1, rst_req and century_clr are each high for exactly one cycle, irq_pulse stays low, and the control register reads back as 0x00.
- R7: On expiry with ctl[7] = 0, irq_pulse is high for exactly one cycle, rst_req and century_clr stay low, and the control register keeps its value.
- R8: After expiry the countdown halts. Further ticks produce no more pulses until a register access re-arms it.
- R9: An access in the same cycle as the final tick wins. No expiry occurs, and the countdown restarts at the full timeout.
- R10: After reset, all outputs are low and the control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per 1/16 second |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_rd | input | 1 | Read strobe for the control register (re-arms) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored control value |
| wd_flag | output | 1 | Sticky expiry flag |
| irq_pulse | output | 1 | One-cycle interrupt on expiry, no steering |
| rst_req | output | 1 | One-cycle reset request on steered expiry |
| century_clr | output | 1 | One-cycle strobe to clear the neighbouring century bit |

## Verification
A wrong count load or decrement shows up as the flag rising on the wrong tick. It is caught within one timeout of the access, because every resolution and multiplier combination is swept and its expiry cycle is compared with the arithmetic product. A wrong steering or halt state shows within a cycle or two: as a pulse on the wrong output, as a second pulse, or as a control register that does or does not read back as zero. A wrong priority between service and the final tick shows as a flag in the very cycle after the collision.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_IRQ  = 2'd1,
    EVT_RST  = 2'd2
  } wdog_evt_e;
endpackage

// File: rtl/wdog_tmo_calc.sv
module wdog_tmo_calc #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic [CNT_W-1:0]  tmo
);
  localparam int NRES = 1 << RES_W;

  logic [CNT_W-1:0] cand [NRES];

  // one shifted candidate per resolution step (x1, x4, x16, ...)
  for (genvar r = 0; r < NRES; r++) begin : g_res
    assign cand[r] = CNT_W'(mult) << (2 * r);
  end

  assign tmo = cand[res];
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_val,
  input  logic             tick,
  output logic             expire,
  output logic             running
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= arm_val;
      run_q <= (arm_val != '0);
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  // access beats the final tick
  assign expire  = run_q && tick && !arm && (cnt_q == CNT_W'(1));
  assign running = run_q;

  assert_zero_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && arm_val == '0) |=> !running);
  assert_halt_after_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !running);
  assert_arm_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && arm_val != '0) |=> running);
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic rearm,
  output logic flag,
  output logic irq,
  output logic rst_req,
  output logic cen_clr
);
  import wdog_pkg::*;

  wdog_evt_e evt_d, evt_q;
  logic      flag_q;

  always_comb begin
    if (!expire)    evt_d = EVT_NONE;
    else if (steer) evt_d = EVT_RST;
    else            evt_d = EVT_IRQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= EVT_NONE;
      flag_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      if (rearm)       flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
    end
  end

  assign flag    = flag_q;
  assign irq     = (evt_q == EVT_IRQ);
  assign rst_req = (evt_q == EVT_RST);
  assign cen_clr = (evt_q == EVT_RST);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req));
  assert_flag_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || rst_req) |-> flag);
  assert_access_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !flag);
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [MULT_W+RES_W:0]       reg_wdata,
  output logic [MULT_W+RES_W:0]       reg_rdata,
  output logic                        wd_flag,
  output logic                        irq_pulse,
  output logic                        rst_req,
  output logic                        century_clr
);
  localparam int CTL_W  = MULT_W + RES_W + 1;
  localparam int STEER  = CTL_W - 1;
  localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [CTL_W-1:0] ctl_q, load_val;
  logic [CNT_W-1:0] tmo;
  logic             rearm, expire, running;

  assign rearm    = reg_wr | reg_rd;
  assign load_val = reg_wr ? reg_wdata : ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     ctl_q <= '0;
    else if (reg_wr)                ctl_q <= reg_wdata;
    else if (expire && ctl_q[STEER]) ctl_q <= '0;
  end

  wdog_tmo_calc #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_calc (
    .mult (load_val[RES_W +: MULT_W]),
    .res  (load_val[RES_W-1:0]),
    .tmo  (tmo)
  );

  wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (rearm),
    .arm_val (tmo),
    .tick    (tick),
    .expire  (expire),
    .running (running)
  );

  wdog_expiry u_exp (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .steer   (ctl_q[STEER]),
    .rearm   (rearm),
    .flag    (wd_flag),
    .irq     (irq_pulse),
    .rst_req (rst_req),
    .cen_clr (century_clr)
  );

  assign reg_rdata = ctl_q;

  assert_ctl_zeroed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctl_q == '0));
  assert_write_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));
  assert_read_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> $stable(reg_rdata));
  assert_flag_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(running));
endmodule

// File: tb/wdog_steer_tb_top.sv
`timescale 1ns/1ps
module wdog_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wd_flag, irq_pulse, rst_req, century_clr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdog_steer dut_i (
    .clk (clk), .rst_n (rst_n), .tick (tick),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .wd_flag (wd_flag), .irq_pulse (irq_pulse),
    .rst_req (rst_req), .century_clr (century_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // watch cyc cycles; first_* = cycle index of first occurrence, -1 if none
  task automatic observe(input int cyc, output int f_flag, output int f_irq,
                         output int f_rst, output int c_irq, output int c_rst);
    f_flag = -1; f_irq = -1; f_rst = -1; c_irq = 0; c_rst = 0;
    for (int k = 1; k <= cyc; k++) begin
      @(negedge clk);
      if (wd_flag && f_flag < 0) f_flag = k;
      if (irq_pulse) begin c_irq++; if (f_irq < 0) f_irq = k; end
      if (rst_req) begin c_rst++; if (f_rst < 0) f_rst = k; end
    end
  endtask

  function automatic int tmo_of(input int v);
    return (1 << (2 * (v & 3))) * ((v >> 2) & 31);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ff, fi, fr, ci, cr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!wd_flag && !irq_pulse && !rst_req && !century_clr, "R10 outputs idle",
          int'({wd_flag, irq_pulse, rst_req, century_clr}), 0);
    check(reg_rdata == 8'h00, "R10 ctl after reset", reg_rdata, 0);

    // R1/R2/R5/R7 sweep over every resolution and multiplier, steering off
    tick = 1'b1;
    for (int v = 0; v < 128; v++) begin
      int n;
      n = tmo_of(v);
      do_write(8'(v));
      observe(n + 3, ff, fi, fr, ci, cr);
      if (n == 0)
        check(ff < 0 && ci == 0 && cr == 0, "R2 disabled value", ff, -1);
      else
        check(ff == n && fi == n && ci == 1 && cr == 0, "R1 expiry tick", ff, n);
    end
    // R7 register keeps value after interrupt
    check(reg_rdata == 8'h7F, "R7 ctl unchanged", reg_rdata, 8'h7F);
    // R8 no further pulses, R5 flag held
    observe(40, ff, fi, fr, ci, cr);
    check(ci == 0 && cr == 0, "R8 halted after expiry", ci + cr, 0);
    check(ff == 1, "R5 flag stays set", ff, 1);

    // R9 access collides with final tick
    do_write(8'h0C);               // multiplier 3, resolution x1
    @(negedge clk); @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check(!wd_flag && !irq_pulse, "R9 access beats last tick", wd_flag, 0);
    @(negedge clk); @(negedge clk);
    check(!wd_flag, "R9 full reload", wd_flag, 0);
    @(negedge clk);
    check(wd_flag && irq_pulse, "R9 expiry after reload", int'({wd_flag, irq_pulse}), 3);

    // R4 read clears flag, keeps value, restarts from stored value
    tick = 1'b0;
    do_read();
    check(!wd_flag, "R4 read clears flag", wd_flag, 0);
    check(reg_rdata == 8'h0C, "R4 read keeps value", reg_rdata, 8'h0C);
    tick = 1'b1;
    observe(6, ff, fi, fr, ci, cr);
    check(ff == 3 && ci == 1, "R4 restart from stored", ff, 3);

    // R1 ticks gate the count
    tick = 1'b0;
    do_write(8'h04);
    observe(10, ff, fi, fr, ci, cr);
    check(ff < 0, "R1 no tick no count", ff, -1);
    // R3 write cleared old flag and stored value
    check(reg_rdata == 8'h04, "R3 write stored", reg_rdata, 8'h04);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(wd_flag && irq_pulse, "R1 single tick expiry", int'({wd_flag, irq_pulse}), 3);

    // R6 steered expiry, multiplier 1 resolution x1
    do_write(8'h84);
    check(!wd_flag, "R3 write clears flag", wd_flag, 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check(rst_req && century_clr && !irq_pulse && wd_flag, "R6 reset strobes",
          int'({rst_req, century_clr, irq_pulse, wd_flag}), 13);
    check(reg_rdata == 8'h00, "R6 ctl zeroed", reg_rdata, 0);
    @(negedge clk);
    check(!rst_req && !century_clr, "R6 one-cycle strobes",
          int'({rst_req, century_clr}), 0);
    tick = 1'b1;
    observe(20, ff, fi, fr, ci, cr);
    check(ci == 0 && cr == 0, "R2 zeroed ctl stays idle", ci + cr, 0);

    // R6 steered with resolution x4
    do_write(8'h85);
    observe(8, ff, fi, fr, ci, cr);
    check(fr == 4 && cr == 1 && ci == 0, "R6 steered timing", fr, 4);
    check(reg_rdata == 8'h00, "R6 ctl zeroed again", reg_rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule